// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a byte-wide serial memory that sits on a two-wire bus with an open-drain data line. A fast system clock samples both bus lines. The block finds start and stop conditions, checks the device select byte against a hardwired strap, and collects a 17-bit word address. It then stores incoming data bytes into an internal array, or returns stored bytes for as long as the master keeps acknowledging them.

The block never drives the data line high. It raises `sda_oe_o` to pull the line low, and a pull-up on the board does the rest. After a write frame ends, a programmable busy interval stands in for the nonvolatile programming time. During that interval the block does not answer at all, so a master can poll with the select byte until it is acknowledged. A write-protect input keeps the array unchanged while it is high.

Only the low `MEM_AW` bits of the 17-bit word address pick a storage location. Higher addresses alias onto the same bytes, but the address counter always counts the full 17 bits.

Top module: `eep_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start. A rising SDA while SCL is high is a stop. A start at any point outside the busy interval drops any partial byte and restarts select-byte decoding. A partial data byte is never stored.
- R2: The select byte is received MSB first. Bits 7..3 must be 10100 and bit 2 must equal `a1_i`. Bit 1 is word-address bit 16 and bit 0 selects read (1) or write (0). On a match the slave acknowledges by holding `sda_oe_o` high through the ninth clock. On a mismatch it stays silent until the next start.
- R3: A write frame is the select byte, then address bits 15..8, then bits 7..0, then data bytes. The slave acknowledges each of these bytes with a low on the ninth clock.
- R4: Within a write, only address bits 7..0 advance after each data byte. Byte 256 of a frame lands back at page offset 0 and overwrites the earlier byte.
- R5: A stop after at least one stored data byte starts a busy interval of `WR_CYCLES` system clocks. During that interval no byte is acknowledged, the slave's own select byte included.
- R6: A read select byte with no address phase returns the byte at the address that follows the last one accessed. After reset that address is 0.
- R7: A random read loads the address through a write frame with no data, followed by a repeated start and a read select byte. While the master acknowledges, reading continues at the next address. The full 17-bit address wraps from 0x1FFFF to 0, with no page wrap. A master non-acknowledge ends the read.
- R8: While `wp_i` is high, all bytes are still acknowledged, but the array is not changed and no busy interval starts.
- R9: After reset `sda_oe_o` is low and every array byte reads 0xFF.
- R10: `sda_oe_o` changes only while the synchronised SCL is low.
- R11: The array stores 2^`MEM_AW` bytes, indexed by the low `MEM_AW` address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, after the wired-AND with other drivers |
| a1_i | input | 1 | Strap compared with select-byte bit 2 |
| wp_i | input | 1 | Write protect, high blocks array updates |
| sda_oe_o | output | 1 | High pulls the data line low |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except when it makes a start or a stop. Each SCL phase lasts longer than the synchroniser delay. It never issues a start or stop while the slave is pulling SDA low. The bench keeps to these rules: every SCL phase lasts ten system clocks, and the master changes SDA five clocks into a low phase. Starts and stops are issued only after a non-acknowledge or after the acknowledge slot has been released.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int ADDR_W = 17;
  localparam logic [4:0] SEL_TAG = 5'b10100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_WAIT
  } eep_state_e;

  typedef enum logic [1:0] {
    K_SEL, K_AHI, K_ALO, K_DATA
  } eep_kind_e;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_ff[STAGES-1];
      sda_p <= sda_ff[STAGES-1];
    end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
  parameter int WR_CYCLES = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                    cnt_q <= '0;
    else if (start_i && !busy_o)    cnt_q <= CW'(WR_CYCLES);
    else if (cnt_q != '0)           cnt_q <= cnt_q - CW'(1);

  assign busy_o = (cnt_q != '0);

  a_r5_busy_begins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
  a_r5_busy_full_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(cnt_q) == CW'(1));
endmodule

// File: rtl/eep_mem_array.sv
module eep_mem_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end

  assign rdata_o = mem_q[addr_i];

  a_r11_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/eep_proto_fsm.sv
module eep_proto_fsm
  import eep_pkg::*;
#(
  parameter int MEM_AW = 11,
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              busy_i,
  input  logic              a1_i,
  input  logic              wp_i,
  input  logic [7:0]        rdata_i,
  output logic              sda_oe_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              wr_start_o
);
  eep_state_e state_q;
  eep_kind_e  kind_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q, hi_q;
  logic [6:0]        tx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              p16_q, rw_q, mack_q, oe_q, pend_q;
  logic              byte_done, sel_hit;

  assign byte_done   = (state_q == ST_RX) && scl_fall_i && (cnt_q == 4'd8);
  assign sel_hit     = (sh_q[7:3] == SEL_TAG) && (sh_q[2] == a1_i);
  assign mem_we_o    = byte_done && (kind_q == K_DATA) && !wp_i && !start_i && !stop_i;
  assign mem_wdata_o = sh_q;
  assign mem_addr_o  = addr_q[MEM_AW-1:0];
  assign wr_start_o  = stop_i && pend_q && !busy_i;
  assign sda_oe_o    = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= K_SEL;
      cnt_q   <= '0;
      sh_q    <= '0;
      hi_q    <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      p16_q   <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else if (start_i && !busy_i) begin
      state_q <= ST_RX;
      kind_q  <= K_SEL;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise_i && cnt_q < 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_s_i};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_done) begin
            unique case (kind_q)
              K_SEL: begin
                if (sel_hit) begin
                  oe_q    <= 1'b1;
                  state_q <= ST_RX_ACK;
                  rw_q    <= sh_q[0];
                  p16_q   <= sh_q[1];
                end else begin
                  state_q <= ST_WAIT;
                end
              end
              K_AHI: begin
                hi_q    <= sh_q;
                oe_q    <= 1'b1;
                state_q <= ST_RX_ACK;
              end
              K_ALO: begin
                addr_q  <= {p16_q, hi_q, sh_q};
                oe_q    <= 1'b1;
                state_q <= ST_RX_ACK;
              end
              K_DATA: begin
                if (!wp_i) pend_q <= 1'b1;
                addr_q  <= {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
                oe_q    <= 1'b1;
                state_q <= ST_RX_ACK;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall_i) begin
            cnt_q <= '0;
            if (kind_q == K_SEL && rw_q) begin
              tx_q    <= rdata_i[6:0];
              oe_q    <= ~rdata_i[7];
              cnt_q   <= 4'd1;
              addr_q  <= addr_q + ADDR_W'(1);
              state_q <= ST_TX;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_RX;
              unique case (kind_q)
                K_SEL:   kind_q <= K_AHI;
                K_AHI:   kind_q <= K_ALO;
                default: kind_q <= K_DATA;
              endcase
            end
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (cnt_q < 4'd8) begin
              oe_q  <= ~tx_q[6];
              tx_q  <= {tx_q[5:0], 1'b0};
              cnt_q <= cnt_q + 4'd1;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_TX_ACK;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) mack_q <= ~sda_s_i;
          else if (scl_fall_i) begin
            if (mack_q) begin
              tx_q    <= rdata_i[6:0];
              oe_q    <= ~rdata_i[7];
              cnt_q   <= 4'd1;
              addr_q  <= addr_q + ADDR_W'(1);
              state_q <= ST_TX;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end

  // oe moves one clock after the synchronised fall is seen
  a_r10_oe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> !scl_s_i);
  a_r4_page_row_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> $stable(addr_q[ADDR_W-1:PAGE_W]));
  a_r2_ack_needs_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) && $past(state_q) == ST_RX |-> $past(cnt_q) == 4'd8);
endmodule

// File: rtl/eep_slave.sv
module eep_slave #(
  parameter int MEM_AW      = 11,
  parameter int PAGE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int WR_CYCLES   = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic a1_i,
  input  logic wp_i,
  output logic sda_oe_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic busy, mem_we, wr_start;
  logic [MEM_AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  eep_proto_fsm #(.MEM_AW(MEM_AW), .PAGE_W(PAGE_W)) u_fsm (
    .clk_i, .rst_ni,
    .scl_s_i(scl_s), .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(bus_start), .stop_i(bus_stop), .busy_i(busy),
    .a1_i, .wp_i, .rdata_i(mem_rdata),
    .sda_oe_o, .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .wr_start_o(wr_start)
  );

  eep_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(wr_start), .busy_o(busy)
  );

  eep_mem_array #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk_i, .rst_ni, .we_i(mem_we), .addr_i(mem_addr),
    .wdata_i(mem_wdata), .rdata_o(mem_rdata)
  );

  a_r5_silent_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_oe_o);
  a_r8_protect_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i && $past(wp_i) && !busy |=> !busy);
endmodule

// File: tb/eep_slave_tb_top.sv
module eep_slave_tb_top;
  localparam int MEM_AW = 11;
  localparam int WRC    = 300;
  localparam int AMASK  = 17'h1FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, sda_w;
  always #10 clk = ~clk;

  assign sda_w = sda_m & ~sda_oe;

  eep_slave #(.MEM_AW(MEM_AW), .WR_CYCLES(WRC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_w),
    .a1_i(1'b0), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  int n_chk = 0, n_err = 0;
  logic [7:0] model [1<<MEM_AW];
  int cur_addr = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] rx_byte;
  event rx_ev;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(rx_ev);
    if (exp_q.size() == 0) chk(1'b0, "R7 unexpected byte", rx_byte, 0);
    else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rx_byte === e, t, rx_byte, e);
    end
  end

  task automatic q_wait(); repeat (5) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; q_wait(); scl_m = 1'b1; q_wait();
    sda_m = 1'b0; q_wait(); scl_m = 1'b0; q_wait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q_wait(); scl_m = 1'b1; q_wait();
    sda_m = 1'b1; q_wait();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; q_wait(); scl_m = 1'b1; q_wait(); q_wait(); scl_m = 1'b0; q_wait();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; q_wait(); scl_m = 1'b1; q_wait();
    ack = !sda_w;
    q_wait(); scl_m = 1'b0; q_wait();
  endtask

  task automatic recv_byte(input bit m_ack);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; q_wait(); scl_m = 1'b1; q_wait();
      b[i] = sda_w;
      q_wait(); scl_m = 1'b0; q_wait();
    end
    sda_m = !m_ack; q_wait(); scl_m = 1'b1; q_wait(); q_wait(); scl_m = 1'b0; q_wait();
    rx_byte = b;
    ->rx_ev;
    #1;
  endtask

  function automatic logic [7:0] sel(input bit rd, input bit p16, input bit a1);
    return {5'b10100, a1, p16, rd};
  endfunction

  task automatic expect_byte(input int a, input string tag);
    exp_q.push_back(model[a & ((1 << MEM_AW) - 1)]);
    tag_q.push_back(tag);
  endtask

  task automatic send_addr(input int a, input string tag);
    bit ack;
    send_byte(sel(0, a[16], 0), ack); chk(ack, {tag, " sel ack"}, ack, 1);
    send_byte(a[15:8], ack);          chk(ack, {tag, " ahi ack"}, ack, 1);
    send_byte(a[7:0], ack);           chk(ack, {tag, " alo ack"}, ack, 1);
  endtask

  task automatic do_write(input int a, input logic [7:0] d[$], input string tag);
    bit ack;
    int wa;
    wa = a;
    bus_start();
    send_addr(a, tag);
    foreach (d[i]) begin
      send_byte(d[i], ack);
      chk(ack, {tag, " data ack"}, ack, 1);
      if (!wp) model[wa & ((1 << MEM_AW) - 1)] = d[i];
      wa = (wa & 32'h1FF00) | ((wa + 1) & 32'hFF);
    end
    bus_stop();
    cur_addr = wa;
  endtask

  task automatic do_read(input int a, input int n, input string tag);
    bit ack;
    int ra;
    bus_start();
    send_addr(a, tag);
    bus_start();
    send_byte(sel(1, 0, 0), ack); chk(ack, {tag, " rd sel ack"}, ack, 1);
    ra = a;
    for (int i = 0; i < n; i++) begin
      expect_byte(ra, tag);
      recv_byte(i < n - 1);
      ra = (ra + 1) & AMASK;
    end
    bus_stop();
    cur_addr = ra;
  endtask

  task automatic cur_read(input int n, input string tag);
    bit ack;
    bus_start();
    send_byte(sel(1, 1, 0), ack); chk(ack, {tag, " cur sel ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      expect_byte(cur_addr, tag);
      recv_byte(i < n - 1);
      cur_addr = (cur_addr + 1) & AMASK;
    end
    bus_stop();
  endtask

  task automatic poll(output bit ack);
    bus_start();
    send_byte(sel(0, 0, 0), ack);
    bus_stop();
  endtask

  task automatic wait_busy(); repeat (WRC + 60) @(negedge clk); endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    bit ack;
    logic [7:0] d[$];
    for (int i = 0; i < (1 << MEM_AW); i++) model[i] = 8'hFF;
    repeat (4) @(negedge clk);
    chk(sda_oe === 1'b0, "R9 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sda_oe === 1'b0, "R9 oe after reset", sda_oe, 0);

    // R6/R9: counter starts at 0, array erased
    cur_read(2, "R6 R9 current read after reset");

    // R3 byte write, R5 busy polling
    d = '{8'hA5};
    do_write(32'h00010, d, "R3 byte write");
    poll(ack); chk(!ack, "R5 nack while busy", ack, 0);
    wait_busy();
    poll(ack); chk(ack, "R5 ack after busy", ack, 1);
    do_read(32'h00010, 1, "R7 random read");
    cur_read(1, "R6 current read follows");

    // R4 page wrap in write; R7/R11 read crosses page
    d = '{8'h11, 8'h22, 8'h33, 8'h44};
    do_write(32'h123FE, d, "R4 page wrap write");
    wait_busy();
    do_read(32'h123FE, 3, "R7 R11 read no page wrap");
    do_read(32'h12300, 2, "R4 wrapped bytes");

    // R4 overwrite beyond a full page
    d = {};
    for (int i = 0; i < 258; i++) d.push_back(8'(i ^ 8'h5A));
    do_write(32'h00200, d, "R4 long page write");
    wait_busy();
    do_read(32'h00200, 3, "R4 overwritten head");
    do_read(32'h002FF, 1, "R4 page tail");

    // R7 full address wrap
    d = '{8'h3C};
    do_write(32'h1FFFF, d, "R7 top byte write");
    wait_busy();
    d = '{8'hC3};
    do_write(32'h00000, d, "R7 zero byte write");
    wait_busy();
    do_read(32'h1FFFF, 2, "R7 wrap to zero");

    // R2 select mismatches
    bus_start(); send_byte(sel(0, 0, 1), ack); bus_stop();
    chk(!ack, "R2 strap mismatch nack", ack, 0);
    bus_start(); send_byte(8'hB0, ack); bus_stop();
    chk(!ack, "R2 tag mismatch nack", ack, 0);

    // R1 restart aborts partial select byte and partial data byte
    bus_start(); send_bits(8'hA1, 4);
    bus_start(); send_addr(32'h00041, "R1 restart after partial sel");
    send_bits(8'h99, 3);
    bus_start();
    send_byte(sel(1, 0, 0), ack); chk(ack, "R1 read after abort", ack, 1);
    expect_byte(32'h00041, "R1 partial data not stored");
    recv_byte(1'b0);
    bus_stop();
    poll(ack); chk(ack, "R1 no busy after aborted byte", ack, 1);

    // R8 write protect
    wp = 1'b1;
    d = '{8'h0F, 8'hF0};
    do_write(32'h00010, d, "R8 protected write acks");
    poll(ack); chk(ack, "R8 no busy when protected", ack, 1);
    wp = 1'b0;
    do_read(32'h00010, 2, "R8 array unchanged");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule